// File: doc/BRIEF.md
# Packet Request to APB Master Bridge

This block turns single-beat request packets into APB master transfers. A request carries a command made of a type, a size and a length, plus a target address, a return address and one data word. It is handed over on a valid/ready channel. The bridge runs the matching APB transfer and, for reads and acknowledged writes, returns a response packet on a second valid/ready channel. In the response the two addresses are swapped, so the packet travels back to whoever sent it.

Sub-word accesses are carried on their natural byte lanes. Write data arrives in lane 0 and is moved up to the addressed lanes, with byte strobes enabling only those lanes. Read data is moved down to lane 0, and the bytes beyond the access width are cleared. A posted write runs the APB write and returns nothing. A slave error is reported in a flag of the response. When the consumer of responses stalls, the bridge holds its response. It starts no further APB transfer until that response is taken.

Top module: `pkt_apb_bridge`

## Requirements
- R1: Out of reset pSel, pEnable and rspValid are low and reqReady is high.
- R2: Every transfer shows exactly one cycle with pSel=1, pEnable=0, then pSel=1, pEnable=1 until pReady=1. pAddr, pWrite, pWdata and pStrb stay stable through the transfer.
- R3: A write request (type 3) drives pWrite=1 and pAddr equal to the target address. With byte offset o = address mod (DATA_W/8) and n = 2^size bytes, pWdata carries request byte b on lane o+b and pStrb has exactly bits o to o+n-1 set. It returns a response of type 4 with zero data.
- R4: A read request (type 1) drives pWrite=0 and pStrb=0. It returns a response of type 2 whose data is pRdata shifted down by o bytes, with bytes n and above cleared.
- R5: A posted write (type 5) performs the same APB write as R3 and produces no response.
- R6: Every response echoes the request's size (3 bits) and len (8 bits). Its target address is the request's return address and its return address is the request's target address. A size larger than log2(DATA_W/8) is treated as a full-width access.
- R7: rspErr is 1 when pSlvErr was high in the completing cycle of the transfer, and 0 otherwise. The response is returned in both cases.
- R8: While rspValid=1 and rspReady=0, the response stays valid with all fields unchanged and no new APB transfer starts.
- R9: reqReady is low during the setup cycle, low during access cycles with pReady=0, and low in idle while a response waits with rspReady=0.
- R10: In idle, a request is accepted in a cycle where a pending response is taken. With zero wait states and rspReady held high, alternating reads and writes complete at one request every 3 cycles.
- R11: A request whose type is not 1, 3 or 5 is accepted and discarded, with no APB transfer and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (APB clock) |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken at this edge when reqValid is high |
| reqType | input | 3 | Request type: 1 read, 3 write, 5 posted write |
| reqSize | input | 3 | log2 of access width in bytes |
| reqLen | input | 8 | Length field, echoed |
| reqDst | input | ADDR_W | Target byte address |
| reqSrc | input | ADDR_W | Return address |
| reqData | input | DATA_W | Write data, byte 0 in lane 0 |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response consumer ready |
| rspType | output | 3 | Response type: 2 read, 4 write |
| rspSize | output | 3 | Echoed size |
| rspLen | output | 8 | Echoed len |
| rspErr | output | 1 | Slave error seen on the transfer |
| rspDst | output | ADDR_W | Request's return address |
| rspSrc | output | ADDR_W | Request's target address |
| rspData | output | DATA_W | Read data in lane 0, zero for writes |
| pSel | output | 1 | APB select |
| pEnable | output | 1 | APB enable |
| pWrite | output | 1 | APB direction |
| pAddr | output | ADDR_W | APB address |
| pWdata | output | DATA_W | APB write data |
| pStrb | output | DATA_W/8 | APB write byte strobes |
| pRdata | input | DATA_W | APB read data |
| pReady | input | 1 | APB slave ready |
| pSlvErr | input | 1 | APB slave error |

## Verification
The assertions take for granted that the APB slave finishes every transfer in a bounded time, and that a requester keeps a presented request's fields steady until it is taken. They also assume sub-word addresses are aligned to their size. The bench keeps to these limits. Its slave inserts between zero and three wait states. Its driver holds each request until the handshake edge. Its random generator rounds every offset down to a multiple of the access width and leaves full-width accesses at offset zero.

// File: rtl/apbbr_pkg.sv
package apbbr_pkg;

  // command codes carried in the 3-bit type field
  localparam logic [2:0] CMD_READ     = 3'd1;
  localparam logic [2:0] CMD_WRITE    = 3'd3;
  localparam logic [2:0] CMD_POSTED   = 3'd5;
  localparam logic [2:0] CMD_READ_RSP = 3'd2;
  localparam logic [2:0] CMD_WR_RSP   = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_HOLD   = 2'd1,   // request latched, waiting for the response slot to drain
    PH_SETUP  = 2'd2,
    PH_ACCESS = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // request handshake at this edge
    logic finish;   // APB transfer completes at this edge
    logic emit;     // a response is written at this edge
    logic drain;    // the held response is taken at this edge
  } strobe_t;

  function automatic logic cmdKnown(input logic [2:0] t);
    return (t == CMD_READ) || (t == CMD_WRITE) || (t == CMD_POSTED);
  endfunction

endpackage

// File: rtl/apbbr_ctrl.sv
module apbbr_ctrl
  import apbbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqType,
  input  logic       curPosted,
  input  logic       rspValid,
  input  logic       rspReady,
  input  logic       pReady,
  output logic       reqReady,
  output logic       pSel,
  output logic       pEnable,
  output strobe_t    strobes
);

  phase_t phase, phaseNext;
  logic   slotFree;
  logic   finish;
  logic   load;
  logic   incomingKnown;

  assign slotFree      = !rspValid || rspReady;
  assign finish        = (phase == PH_ACCESS) && pReady;
  assign incomingKnown = cmdKnown(reqType);

  // a new request is taken in idle once the response slot is free, or in
  // the completing access cycle (the slot is always empty during a transfer)
  assign reqReady = ((phase == PH_IDLE) && slotFree) || finish;
  assign load     = reqValid && reqReady;

  assign strobes.load   = load;
  assign strobes.finish = finish;
  assign strobes.emit   = finish && !curPosted;
  assign strobes.drain  = rspValid && rspReady;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (load && incomingKnown) phaseNext = PH_SETUP;
      end
      PH_HOLD: begin
        if (rspReady) phaseNext = PH_SETUP;
      end
      PH_SETUP: begin
        phaseNext = PH_ACCESS;
      end
      PH_ACCESS: begin
        if (pReady) begin
          if (load && incomingKnown)
            phaseNext = curPosted ? PH_SETUP : PH_HOLD;
          else
            phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign pSel    = (phase == PH_SETUP) || (phase == PH_ACCESS);
  assign pEnable = (phase == PH_ACCESS);

endmodule

// File: rtl/apbbr_dpath.sv
module apbbr_dpath
  import apbbr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic [2:0]            reqType,
  input  logic [2:0]            reqSize,
  input  logic [7:0]            reqLen,
  input  logic [ADDR_W-1:0]     reqDst,
  input  logic [ADDR_W-1:0]     reqSrc,
  input  logic [DATA_W-1:0]     reqData,
  input  logic [DATA_W-1:0]     pRdata,
  input  logic                  pSlvErr,
  output logic                  curPosted,
  output logic                  pWrite,
  output logic [ADDR_W-1:0]     pAddr,
  output logic [DATA_W-1:0]     pWdata,
  output logic [DATA_W/8-1:0]   pStrb,
  output logic                  rspValid,
  output logic [2:0]            rspType,
  output logic [2:0]            rspSize,
  output logic [7:0]            rspLen,
  output logic                  rspErr,
  output logic [ADDR_W-1:0]     rspDst,
  output logic [ADDR_W-1:0]     rspSrc,
  output logic [DATA_W-1:0]     rspData
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  // byte lanes [off, off + 2^size) enabled; oversize clamps to full width
  function automatic logic [BYTES-1:0] laneMask(input logic [2:0] sz,
                                                input logic [OFF_W-1:0] off);
    logic [BYTES-1:0] m;
    int eff;
    int span;
    int first;
    eff   = (int'(sz) > OFF_W) ? OFF_W : int'(sz);
    span  = 1 << eff;
    first = int'(off);
    for (int i = 0; i < BYTES; i++)
      m[i] = (i >= first) && (i < first + span);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] expandBytes(input logic [BYTES-1:0] m);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < BYTES; i++)
      w[i*8 +: 8] = {8{m[i]}};
    return w;
  endfunction

  // latched request
  logic [2:0]        curType;
  logic [2:0]        curSize;
  logic [7:0]        curLen;
  logic [ADDR_W-1:0] curDst;
  logic [ADDR_W-1:0] curSrc;
  logic [DATA_W-1:0] curWdata;
  logic [BYTES-1:0]  curStrb;

  logic [OFF_W-1:0]  reqOff;
  logic [OFF_W-1:0]  curOff;
  logic              curIsRead;
  logic [DATA_W-1:0] loadWdata;
  logic [BYTES-1:0]  loadStrb;
  logic [DATA_W-1:0] rdShifted;
  logic [DATA_W-1:0] rdKeep;

  assign reqOff    = reqDst[OFF_W-1:0];
  assign curOff    = curDst[OFF_W-1:0];
  assign curIsRead = (curType == CMD_READ);

  assign loadWdata = reqData << {reqOff, 3'b000};
  assign loadStrb  = (reqType == CMD_READ) ? '0 : laneMask(reqSize, reqOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curType   <= '0;
      curSize   <= '0;
      curLen    <= '0;
      curDst    <= '0;
      curSrc    <= '0;
      curWdata  <= '0;
      curStrb   <= '0;
      curPosted <= 1'b0;
    end else if (strobes.load) begin
      curType   <= reqType;
      curSize   <= reqSize;
      curLen    <= reqLen;
      curDst    <= reqDst;
      curSrc    <= reqSrc;
      curWdata  <= loadWdata;
      curStrb   <= loadStrb;
      curPosted <= (reqType == CMD_POSTED);
    end
  end

  assign pWrite = !curIsRead;
  assign pAddr  = curDst;
  assign pWdata = curWdata;
  assign pStrb  = curStrb;

  // read return: move the addressed lanes down to lane 0, clear the rest
  assign rdShifted = pRdata >> {curOff, 3'b000};
  assign rdKeep    = expandBytes(laneMask(curSize, '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspType  <= '0;
      rspSize  <= '0;
      rspLen   <= '0;
      rspErr   <= 1'b0;
      rspDst   <= '0;
      rspSrc   <= '0;
      rspData  <= '0;
    end else if (strobes.emit) begin
      rspValid <= 1'b1;
      rspType  <= curIsRead ? CMD_READ_RSP : CMD_WR_RSP;
      rspSize  <= curSize;
      rspLen   <= curLen;
      rspErr   <= pSlvErr;
      rspDst   <= curSrc;
      rspSrc   <= curDst;
      rspData  <= curIsRead ? (rdShifted & rdKeep) : '0;
    end else if (strobes.drain) begin
      rspValid <= 1'b0;
    end
  end

endmodule

// File: rtl/pkt_apb_bridge.sv
module pkt_apb_bridge
  import apbbr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [2:0]          reqType,
  input  logic [2:0]          reqSize,
  input  logic [7:0]          reqLen,
  input  logic [ADDR_W-1:0]   reqDst,
  input  logic [ADDR_W-1:0]   reqSrc,
  input  logic [DATA_W-1:0]   reqData,
  output logic                rspValid,
  input  logic                rspReady,
  output logic [2:0]          rspType,
  output logic [2:0]          rspSize,
  output logic [7:0]          rspLen,
  output logic                rspErr,
  output logic [ADDR_W-1:0]   rspDst,
  output logic [ADDR_W-1:0]   rspSrc,
  output logic [DATA_W-1:0]   rspData,
  output logic                pSel,
  output logic                pEnable,
  output logic                pWrite,
  output logic [ADDR_W-1:0]   pAddr,
  output logic [DATA_W-1:0]   pWdata,
  output logic [DATA_W/8-1:0] pStrb,
  input  logic [DATA_W-1:0]   pRdata,
  input  logic                pReady,
  input  logic                pSlvErr
);

  strobe_t strobes;
  logic    curPosted;

  apbbr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqType   (reqType),
    .curPosted (curPosted),
    .rspValid  (rspValid),
    .rspReady  (rspReady),
    .pReady    (pReady),
    .reqReady  (reqReady),
    .pSel      (pSel),
    .pEnable   (pEnable),
    .strobes   (strobes)
  );

  apbbr_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqType   (reqType),
    .reqSize   (reqSize),
    .reqLen    (reqLen),
    .reqDst    (reqDst),
    .reqSrc    (reqSrc),
    .reqData   (reqData),
    .pRdata    (pRdata),
    .pSlvErr   (pSlvErr),
    .curPosted (curPosted),
    .pWrite    (pWrite),
    .pAddr     (pAddr),
    .pWdata    (pWdata),
    .pStrb     (pStrb),
    .rspValid  (rspValid),
    .rspType   (rspType),
    .rspSize   (rspSize),
    .rspLen    (rspLen),
    .rspErr    (rspErr),
    .rspDst    (rspDst),
    .rspSrc    (rspSrc),
    .rspData   (rspData)
  );

endmodule

// File: rtl/apbbr_chk.sv
module apbbr_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqReady,
  input logic                rspValid,
  input logic                rspReady,
  input logic [2:0]          rspType,
  input logic                rspErr,
  input logic [ADDR_W-1:0]   rspDst,
  input logic [ADDR_W-1:0]   rspSrc,
  input logic [DATA_W-1:0]   rspData,
  input logic                pSel,
  input logic                pEnable,
  input logic                pWrite,
  input logic [ADDR_W-1:0]   pAddr,
  input logic [DATA_W-1:0]   pWdata,
  input logic [DATA_W/8-1:0] pStrb,
  input logic                pReady
);

  a_r2_setup_then_access: assert property (@(posedge clk) disable iff (!rstN)
    pSel && !pEnable |=> pSel && pEnable);

  a_r2_enable_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    pEnable |-> pSel);

  a_r2_stable_while_waiting: assert property (@(posedge clk) disable iff (!rstN)
    pSel && pEnable && !pReady |=> pSel && pEnable && $stable(pAddr) &&
      $stable(pWrite) && $stable(pWdata) && $stable(pStrb));

  a_r3_write_has_strobe: assert property (@(posedge clk) disable iff (!rstN)
    pSel && pWrite |-> pStrb != '0);

  a_r4_read_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    pSel && !pWrite |-> pStrb == '0);

  a_r6_response_type: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspType == 3'd2) || (rspType == 3'd4));

  a_r8_response_held: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspType) && $stable(rspErr) &&
      $stable(rspDst) && $stable(rspSrc) && $stable(rspData));

  a_r8_no_transfer_with_pending: assert property (@(posedge clk) disable iff (!rstN)
    pSel |-> !rspValid);

  a_r9_no_take_in_setup: assert property (@(posedge clk) disable iff (!rstN)
    pSel && !pEnable |-> !reqReady);

  a_r9_no_take_while_waiting: assert property (@(posedge clk) disable iff (!rstN)
    pSel && pEnable && !pReady |-> !reqReady);

  a_r9_no_take_when_blocked: assert property (@(posedge clk) disable iff (!rstN)
    !pSel && rspValid && !rspReady |-> !reqReady);

endmodule

bind pkt_apb_bridge apbbr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspType  (rspType),
  .rspErr   (rspErr),
  .rspDst   (rspDst),
  .rspSrc   (rspSrc),
  .rspData  (rspData),
  .pSel     (pSel),
  .pEnable  (pEnable),
  .pWrite   (pWrite),
  .pAddr    (pAddr),
  .pWdata   (pWdata),
  .pStrb    (pStrb),
  .pReady   (pReady)
);

// File: tb/test_pkt_apb_bridge.sv
`timescale 1ns/1ps
module test_pkt_apb_bridge;

  localparam int DW    = 64;
  localparam int AW    = 64;
  localparam int BYTES = DW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          reqValid, reqReady;
  logic [2:0]    reqType, reqSize;
  logic [7:0]    reqLen;
  logic [AW-1:0] reqDst, reqSrc;
  logic [DW-1:0] reqData;
  logic          rspValid, rspReady;
  logic [2:0]    rspType, rspSize;
  logic [7:0]    rspLen;
  logic          rspErr;
  logic [AW-1:0] rspDst, rspSrc;
  logic [DW-1:0] rspData;
  logic          pSel, pEnable, pWrite;
  logic [AW-1:0] pAddr;
  logic [DW-1:0] pWdata;
  logic [BYTES-1:0] pStrb;
  logic [DW-1:0] pRdata;
  logic          pReady, pSlvErr;

  pkt_apb_bridge #(.DATA_W(DW), .ADDR_W(AW)) i_pkt_apb_bridge (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqType(reqType), .reqSize(reqSize),
    .reqLen(reqLen), .reqDst(reqDst), .reqSrc(reqSrc), .reqData(reqData),
    .rspValid(rspValid), .rspReady(rspReady), .rspType(rspType), .rspSize(rspSize),
    .rspLen(rspLen), .rspErr(rspErr), .rspDst(rspDst), .rspSrc(rspSrc), .rspData(rspData),
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .pAddr(pAddr), .pWdata(pWdata),
    .pStrb(pStrb), .pRdata(pRdata), .pReady(pReady), .pSlvErr(pSlvErr)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // ---------------- APB slave model: 32 words, error when address bit 12 set
  logic [DW-1:0] slvMem [32];
  logic [DW-1:0] refMem [32];
  int  waitMax  = 0;
  int  waitCnt  = 0;
  int  xferCount = 0;
  logic slvErrAddr;
  assign slvErrAddr = pAddr[12];
  assign pReady  = (waitCnt == 0);
  assign pRdata  = slvErrAddr ? '0 : slvMem[pAddr[7:3]];
  assign pSlvErr = pSel && pEnable && slvErrAddr;

  always @(posedge clk) begin
    if (pSel && !pEnable) begin
      waitCnt   <= (waitMax == 0) ? 0 : int'($urandom_range(waitMax, 0));
      xferCount <= xferCount + 1;
    end else if (pSel && pEnable && waitCnt != 0) begin
      waitCnt <= waitCnt - 1;
    end
    if (pSel && pEnable && pReady && pWrite && !slvErrAddr)
      for (int b = 0; b < BYTES; b++)
        if (pStrb[b]) slvMem[pAddr[7:3]][b*8 +: 8] <= pWdata[b*8 +: 8];
  end

  // ---------------- expected responses
  typedef struct packed {
    logic [2:0]  t;
    logic [2:0]  s;
    logic [7:0]  l;
    logic        e;
    logic [63:0] dst;
    logic [63:0] src;
    logic [63:0] data;
  } exp_t;
  exp_t expQ[$];
  int expXfers = 0;

  // response monitor: a handshake visible after the falling edge happens at the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && rspValid && rspReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected response type", {61'd0, rspType}, 64'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(rspType == e.t, (e.t == 3'd2) ? "R4" : "R3", "response type", {61'd0, rspType}, {61'd0, e.t});
          check(rspData == e.data, (e.t == 3'd2) ? "R4" : "R3", "response data", rspData, e.data);
          check(rspSize == e.s && rspLen == e.l, "R6", "size/len echo",
                {53'd0, rspSize, rspLen}, {53'd0, e.s, e.l});
          check(rspDst == e.dst && rspSrc == e.src, "R6", "address swap", rspDst ^ e.dst, rspSrc ^ e.src);
          check(rspErr == e.e, "R7", "error flag", {63'd0, rspErr}, {63'd0, e.e});
        end
      end
    end
  end

  // ---------------- request driver with its own reference model
  task automatic sendReq(input logic [2:0] t, input logic [2:0] s, input logic [7:0] l,
                         input logic [63:0] dst, input logic [63:0] src, input logic [63:0] d);
    int eff, span, off, idx;
    bit ok;
    logic err;
    logic [63:0] w;
    exp_t e;
    eff  = (s > 3'd3) ? 3 : int'(s);
    span = 1 << eff;
    off  = int'(dst[2:0]);
    idx  = int'(dst[7:3]);
    err  = dst[12];
    e.t = 3'd0; e.s = s; e.l = l; e.e = err; e.dst = src; e.src = dst; e.data = '0;
    if (t == 3'd1) begin
      w = err ? 64'd0 : (refMem[idx] >> (off * 8));
      for (int b = span; b < BYTES; b++) w[b*8 +: 8] = 8'd0;
      e.t = 3'd2; e.data = w;
      expQ.push_back(e);
      expXfers++;
    end else if (t == 3'd3 || t == 3'd5) begin
      if (!err)
        for (int b = 0; b < span; b++)
          if (off + b < BYTES) refMem[idx][(off + b)*8 +: 8] = d[b*8 +: 8];
      if (t == 3'd3) begin
        e.t = 3'd4;
        expQ.push_back(e);
      end
      expXfers++;
    end
    reqValid = 1'b1; reqType = t; reqSize = s; reqLen = l;
    reqDst = dst; reqSrc = src; reqData = d;
    do begin
      #1;
      ok = reqReady;
      @(negedge clk);
    end while (!ok);
    reqValid = 1'b0;
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && expQ.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [63:0] mkAddr(input int idx, input int off, input bit err);
    logic [63:0] a;
    a = {$urandom, $urandom};
    a[12]  = err;
    a[7:3] = idx[4:0];
    a[2:0] = off[2:0];
    return a;
  endfunction

  bit randRdy = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (randRdy) rspReady = ($urandom % 4) != 0;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
    finishRun();
  end

  initial begin
    int x0, c0, c1;
    logic [63:0] heldData, heldDst;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) begin slvMem[i] = '0; refMem[i] = '0; end
    reqValid = 0; reqType = 0; reqSize = 0; reqLen = 0; reqDst = 0; reqSrc = 0; reqData = 0;
    rspReady = 1;

    repeat (3) @(negedge clk);
    #1;
    check(!pSel && !pEnable, "R1", "APB idle in reset", {62'd0, pSel, pEnable}, 64'd0);
    check(!rspValid && reqReady, "R1", "handshake state in reset", {62'd0, rspValid, reqReady}, 64'd1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!pSel && !rspValid && reqReady, "R1", "state after reset",
          {61'd0, pSel, rspValid, reqReady}, 64'd1);
    @(negedge clk);

    // R3/R4 full-width write then read back
    sendReq(3'd3, 3'd3, 8'd0, mkAddr(1, 0, 0), 64'h0000_0000_0000_00A1, 64'h1122_3344_5566_7788);
    sendReq(3'd1, 3'd3, 8'd7, mkAddr(1, 0, 0), 64'h0000_0000_0000_00A2, 64'd0);
    // R3/R4 sub-word lanes
    sendReq(3'd3, 3'd0, 8'd1, mkAddr(1, 5, 0), 64'hB0, 64'hFFFF_FFFF_FFFF_FFEE);
    sendReq(3'd3, 3'd1, 8'd2, mkAddr(1, 2, 0), 64'hB1, 64'h0000_0000_0000_CAFE);
    sendReq(3'd3, 3'd2, 8'd3, mkAddr(2, 4, 0), 64'hB2, 64'h1234_5678_DEAD_BEEF);
    sendReq(3'd1, 3'd0, 8'd4, mkAddr(1, 5, 0), 64'hB3, 64'd0);
    sendReq(3'd1, 3'd1, 8'd5, mkAddr(1, 2, 0), 64'hB4, 64'd0);
    sendReq(3'd1, 3'd2, 8'd6, mkAddr(2, 4, 0), 64'hB5, 64'd0);
    sendReq(3'd1, 3'd3, 8'd9, mkAddr(1, 0, 0), 64'hB6, 64'd0);
    // R6 oversize is full width
    sendReq(3'd3, 3'd6, 8'd0, mkAddr(3, 0, 0), 64'hC0, 64'h0F0E_0D0C_0B0A_0908);
    sendReq(3'd1, 3'd7, 8'd0, mkAddr(3, 0, 0), 64'hC1, 64'd0);
    // R7 slave error on write, read and posted write
    sendReq(3'd3, 3'd3, 8'd0, mkAddr(4, 0, 1), 64'hD0, 64'hBAD0_BAD0_BAD0_BAD0);
    sendReq(3'd1, 3'd3, 8'd0, mkAddr(4, 0, 1), 64'hD1, 64'd0);
    sendReq(3'd5, 3'd3, 8'd0, mkAddr(4, 0, 1), 64'hD2, 64'hBAD1_BAD1_BAD1_BAD1);
    sendReq(3'd1, 3'd3, 8'd0, mkAddr(4, 0, 0), 64'hD3, 64'd0);
    // R5 posted writes, then read back
    sendReq(3'd5, 3'd3, 8'd0, mkAddr(5, 0, 0), 64'hE0, 64'hCAFE_BABE_0000_0001);
    sendReq(3'd5, 3'd2, 8'd0, mkAddr(6, 4, 0), 64'hE1, 64'h0000_0000_ABCD_1234);
    sendReq(3'd1, 3'd3, 8'd0, mkAddr(5, 0, 0), 64'hE2, 64'd0);
    sendReq(3'd1, 3'd3, 8'd0, mkAddr(6, 0, 0), 64'hE3, 64'd0);
    drain(200);
    check(expQ.size() == 0, "R5", "all directed responses seen", expQ.size(), 64'd0);

    // R11 unknown types: no transfer, no response
    x0 = xferCount;
    sendReq(3'd0, 3'd3, 8'd0, mkAddr(7, 0, 0), 64'hF0, 64'hFFFF);
    sendReq(3'd7, 3'd3, 8'd0, mkAddr(7, 0, 0), 64'hF1, 64'hFFFF);
    sendReq(3'd2, 3'd3, 8'd0, mkAddr(7, 0, 0), 64'hF2, 64'hFFFF);
    repeat (6) @(negedge clk);
    #1;
    check(xferCount == x0, "R11", "no APB transfer for unknown types", xferCount, x0);
    check(!rspValid, "R11", "no response for unknown types", {63'd0, rspValid}, 64'd0);
    sendReq(3'd1, 3'd3, 8'd0, mkAddr(7, 0, 0), 64'hF3, 64'd0);
    drain(100);

    // R8/R9/R10 backpressure
    rspReady = 1'b0;
    sendReq(3'd3, 3'd3, 8'd0, mkAddr(8, 0, 0), 64'h91, 64'h5555_AAAA_5555_AAAA);
    repeat (3) @(negedge clk);
    heldData = rspData; heldDst = rspDst;
    x0 = xferCount;
    fork
      sendReq(3'd1, 3'd3, 8'd0, mkAddr(8, 0, 0), 64'h92, 64'd0);
      begin
        repeat (8) @(negedge clk);
        #1;
        check(rspValid == 1'b1, "R8", "response held under backpressure", {63'd0, rspValid}, 64'd1);
        check(rspData == heldData && rspDst == heldDst, "R8", "held response stable", rspDst, heldDst);
        check(xferCount == x0, "R8", "no transfer while response pending", xferCount, x0);
        check(reqReady == 1'b0, "R9", "request refused while response blocked", {63'd0, reqReady}, 64'd0);
        @(negedge clk);
        rspReady = 1'b1;
        #1;
        check(reqReady && rspValid, "R10", "request taken as pending response drains",
              {62'd0, reqReady, rspValid}, 64'd3);
      end
    join
    drain(100);

    // R10 throughput, alternating reads and writes
    waitMax = 0;
    rspReady = 1'b1;
    c0 = cyc;
    for (int i = 0; i < 20; i++)
      sendReq((i % 2) ? 3'd3 : 3'd1, 3'd3, 8'(i), mkAddr(9 + (i % 4), 0, 0),
              64'(i), {$urandom, $urandom});
    c1 = cyc;
    check(c1 - c0 <= 60, "R10", "20 alternating requests within 60 cycles", c1 - c0, 64'd60);
    drain(200);

    // random phase (R2..R7), wait states and random response backpressure
    waitMax = 3;
    randRdy = 1;
    for (int n = 0; n < 400; n++) begin
      int pick, sz, eff, span, off;
      logic [2:0] t;
      pick = int'($urandom % 100);
      if (pick < 40)      t = 3'd1;
      else if (pick < 72) t = 3'd3;
      else if (pick < 94) t = 3'd5;
      else                t = (pick % 2) ? 3'd7 : 3'd6;
      sz   = int'($urandom % 8);
      eff  = (sz > 3) ? 3 : sz;
      span = 1 << eff;
      off  = int'($urandom % 8) & ~(span - 1);
      sendReq(t, 3'(sz), 8'($urandom), mkAddr(int'($urandom % 32), off, ($urandom % 10) == 0),
              {$urandom, $urandom}, {$urandom, $urandom});
    end
    randRdy = 0;
    rspReady = 1'b1;
    drain(2000);
    check(expQ.size() == 0, "R5", "no response lost or added", expQ.size(), 64'd0);
    check(xferCount == expXfers, "R11", "transfer count matches known requests", xferCount, expXfers);
    for (int i = 0; i < 32; i++)
      check(slvMem[i] == refMem[i], "R3", $sformatf("memory word %0d", i), slvMem[i], refMem[i]);

    finishRun();
  end

endmodule